// File: doc/BRIEF.md
# Adjacent-Burst Correcting Memory ECC

This block wraps a simple dual-port RAM (one write port, one read port) with an error-correcting code that protects 32-bit data words. On the write side it turns each full data word into a 48-bit stored word. On the read side it takes the stored word returned by the RAM, computes syndromes, corrects the data, and reports two flags with it. `rd_err` means an error was seen. `rd_ue` means the error could not be corrected.

The stored word is built from three independent SEC-DED Hamming codewords of 16 bits each. Group g carries data bits whose index modulo 3 equals g. The groups are interleaved bit by bit, so stored bit `3*k+g` is position k of group g. A burst of one, two or three neighbouring stored bits therefore touches each group at most once, and each group can repair that single error on its own. The RAM itself lives outside the block and talks to it over the `mem_*` pins. An optional register stage in front of the decoders (`PIPE=1`) shortens the critical path at the cost of one extra cycle of read latency.

Top module: `burst_ecc_sdp`

## Requirements
- R1: Each write sends the complete 32-bit word, encoded into 48 bits, to the RAM in the same cycle; there are no partial-word writes. Reading back an unaltered word returns the written data with `rd_err=0` and `rd_ue=0`. The write and read ports work independently in the same cycle.
- R2: Any single flipped bit among the 48 stored bits is corrected: the exact written data is returned with `rd_err=1` and `rd_ue=0`.
- R3: Any two flipped neighbouring stored bits (bits b and b+1) are corrected, with `rd_err=1` and `rd_ue=0`.
- R4: Any three flipped neighbouring stored bits (b, b+1, b+2) are corrected, with `rd_err=1` and `rd_ue=0`.
- R5: A double error inside one group is flagged with `rd_err=1` and `rd_ue=1`, and the data bits are passed through uncorrected. In group 0, codeword positions 1, 2, 3 and 4 sit at stored bits 3, 6, 9 and 12, and data bit 0 is codeword position 3 (stored bit 9).
- R6: `rd_ue` is never high unless `rd_err` is also high.
- R7: With `PIPE=0`, `rd_valid` and the data and flags of a read appear one cycle after `rd_en`. With `PIPE=1` they appear two cycles after. Back-to-back reads return back-to-back results in order.
- R8: `rd_err` and `rd_ue` are low whenever `rd_valid` is low, and `rd_valid` is low during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Data word to protect |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Corrected (or passed-through) read data |
| rd_valid | output | 1 | Read result valid |
| rd_err | output | 1 | An error was seen in this word |
| rd_ue | output | 1 | The error could not be corrected |
| mem_we | output | 1 | RAM write enable |
| mem_waddr | output | ADDR_W | RAM write address |
| mem_wdata | output | 48 | Encoded stored word to RAM |
| mem_re | output | 1 | RAM read enable |
| mem_raddr | output | ADDR_W | RAM read address |
| mem_rdata | input | 48 | Stored word from RAM, one cycle after mem_re |

## Verification
On every cycle the assertions check four things. The flag ordering must hold (`rd_ue` implies `rd_err`). The valid latency must be right for the chosen pipeline setting. Each encoded group must have even parity. And for each group, the decoder output is compared against the raw data bits taken from the stored word: it must equal them when the group is clean or uncorrectable, and differ from them in at most one bit when a correction is made. Only the bench scenarios can show that every single, adjacent-double and adjacent-triple flip over all 48 stored bits gives back exactly the written data, that a same-group double error passes the data through with both flags set, and that both pipeline variants keep results in order.

// File: rtl/burst_ecc_pkg.sv
`timescale 1ns/1ps
package burst_ecc_pkg;

  // Result of decoding one interleaved group
  typedef enum logic [1:0] {
    DEC_CLEAN  = 2'd0,
    DEC_FIXED  = 2'd1,
    DEC_UNCORR = 2'd2
  } dec_stat_e;

  // Number of Hamming check bits needed to cover gd data bits
  function automatic int par_bits(input int gd);
    int p;
    p = 1;
    while ((1 << p) < gd + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Codeword position (1-based, skipping check positions) of data bit j
  function automatic int data_pos(input int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int pos = 1; pos < 256; pos++) begin
      if (!is_pow2(pos)) begin
        if (cnt == j) res = pos;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/burst_ecc_grp_enc.sv
`timescale 1ns/1ps
module burst_ecc_grp_enc
  import burst_ecc_pkg::*;
#(
  parameter int GD = 11,
  parameter int P  = 4,
  parameter int CW = GD + P + 1
) (
  input  logic [GD-1:0] grp_data,
  output logic [CW-1:0] grp_cw
);

  logic [CW-1:0] tmp;

  always_comb begin
    int j;
    logic par;
    tmp = '0;
    j   = 0;
    // place data bits on the non-power-of-two positions
    for (int pos = 1; pos < CW; pos++) begin
      if (!is_pow2(pos)) begin
        tmp[pos] = grp_data[j];
        j++;
      end
    end
    // check bit i covers every position with bit i set
    for (int i = 0; i < P; i++) begin
      par = 1'b0;
      for (int pos = 1; pos < CW; pos++) begin
        if ((pos & (1 << i)) != 0) par = par ^ tmp[pos];
      end
      tmp[1 << i] = par;
    end
    // position 0 makes the whole codeword even parity
    tmp[0] = ^tmp[CW-1:1];
    grp_cw = tmp;
  end

endmodule

// File: rtl/burst_ecc_grp_dec.sv
`timescale 1ns/1ps
module burst_ecc_grp_dec
  import burst_ecc_pkg::*;
#(
  parameter int GD = 11,
  parameter int P  = 4,
  parameter int CW = GD + P + 1
) (
  input  logic [CW-1:0] grp_cw,
  output logic [GD-1:0] grp_data,
  output dec_stat_e     grp_stat
);

  logic [P-1:0]  syn;
  logic          ovr;
  logic [CW-1:0] fix;

  // syndrome and overall parity
  always_comb begin
    syn = '0;
    for (int pos = 1; pos < CW; pos++) begin
      if (grp_cw[pos]) syn = syn ^ pos[P-1:0];
    end
    ovr = ^grp_cw;
  end

  // classification and single-bit repair
  always_comb begin
    fix      = grp_cw;
    grp_stat = DEC_CLEAN;
    if ((syn != '0) || ovr) begin
      if (!ovr) begin
        grp_stat = DEC_UNCORR;        // even parity, non-zero syndrome
      end else if (int'(syn) >= CW) begin
        grp_stat = DEC_UNCORR;        // points outside the codeword
      end else begin
        grp_stat = DEC_FIXED;
        fix[syn] = ~grp_cw[syn];
      end
    end
  end

  // pull the data bits back out of the repaired codeword
  always_comb begin
    int j;
    grp_data = '0;
    j = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if (!is_pow2(pos)) begin
        grp_data[j] = fix[pos];
        j++;
      end
    end
  end

endmodule

// File: rtl/burst_ecc_sdp.sv
`timescale 1ns/1ps
module burst_ecc_sdp
  import burst_ecc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NGRP   = 3,
  parameter bit PIPE   = 1'b0,
  localparam int GD      = (DATA_W + NGRP - 1) / NGRP,
  localparam int P       = par_bits(GD),
  localparam int CW      = GD + P + 1,
  localparam int STORE_W = NGRP * CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic               rd_err,
  output logic               rd_ue,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_waddr,
  output logic [STORE_W-1:0] mem_wdata,
  output logic               mem_re,
  output logic [ADDR_W-1:0]  mem_raddr,
  input  logic [STORE_W-1:0] mem_rdata
);

  logic [NGRP-1:0][GD-1:0] enc_din;
  logic [NGRP-1:0][CW-1:0] enc_cw;
  logic [NGRP-1:0][CW-1:0] dec_cw;
  logic [NGRP-1:0][GD-1:0] dec_dout;
  logic [NGRP-1:0][GD-1:0] raw_d;
  dec_stat_e               dec_stat [NGRP];
  logic [NGRP-1:0]         grp_err;
  logic [NGRP-1:0]         grp_unc;
  logic [NGRP*GD-1:0]      pad_flag;

  logic [STORE_W-1:0]      dec_word;
  logic                    dec_vld;

  // ---------------- write side ----------------
  assign mem_we    = wr_en;
  assign mem_waddr = wr_addr;
  assign mem_re    = rd_en;
  assign mem_raddr = rd_addr;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    // split data by index modulo NGRP
    for (genvar j = 0; j < GD; j++) begin : g_bit
      if (NGRP * j + g < DATA_W) begin : g_real
        assign enc_din[g][j]             = wr_data[NGRP*j+g];
        assign rd_data[NGRP*j+g]         = dec_dout[g][j];
        assign pad_flag[g*GD+j]          = 1'b0;
      end else begin : g_pad
        assign enc_din[g][j]             = 1'b0;
        // a padding bit decoding to one means the repair went wrong
        assign pad_flag[g*GD+j]          = dec_dout[g][j];
      end
      assign raw_d[g][j] = dec_cw[g][data_pos(j)];
    end

    // bit-level interleave of the group codewords
    for (genvar k = 0; k < CW; k++) begin : g_ilv
      assign mem_wdata[NGRP*k+g] = enc_cw[g][k];
      assign dec_cw[g][k]        = dec_word[NGRP*k+g];
    end

    burst_ecc_grp_enc #(.GD(GD), .P(P), .CW(CW)) u_enc (
      .grp_data (enc_din[g]),
      .grp_cw   (enc_cw[g])
    );

    burst_ecc_grp_dec #(.GD(GD), .P(P), .CW(CW)) u_dec (
      .grp_cw   (dec_cw[g]),
      .grp_data (dec_dout[g]),
      .grp_stat (dec_stat[g])
    );

    assign grp_err[g] = (dec_stat[g] != DEC_CLEAN);
    assign grp_unc[g] = (dec_stat[g] == DEC_UNCORR);

    AST_UE_PASS:   assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && grp_unc[g]) |-> (dec_dout[g] == raw_d[g]));                // R5
    AST_CLEAN_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && !grp_err[g]) |-> (dec_dout[g] == raw_d[g]));              // R1
    AST_FIX_ONE:   assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && grp_err[g] && !grp_unc[g]) |->
        ($countones(dec_dout[g] ^ raw_d[g]) <= 1));                          // R2
    AST_ENC_EVEN:  assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((^enc_cw[g]) == 1'b0));                                     // R1
  end

  // ---------------- read side ----------------
  logic vld1_d, vld1_q;

  always_comb begin
    vld1_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld1_q <= 1'b0;
    else        vld1_q <= vld1_d;
  end

  if (PIPE) begin : g_pipe
    logic               vld2_d, vld2_q;
    logic [STORE_W-1:0] word_d, word_q;

    always_comb begin
      vld2_d = vld1_q;
      word_d = word_q;
      if (vld1_q) word_d = mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld2_q <= 1'b0;
      else        vld2_q <= vld2_d;
    end

    always_ff @(posedge clk) begin
      if (vld1_q) word_q <= word_d;
    end

    assign dec_word = word_q;
    assign dec_vld  = vld2_q;

    AST_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == $past(rd_en, 2));                                          // R7
  end else begin : g_nopipe
    assign dec_word = mem_rdata;
    assign dec_vld  = vld1_q;

    AST_LAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == $past(rd_en));                                             // R7
  end

  assign rd_valid = dec_vld;
  assign rd_err   = dec_vld & (|grp_err);
  assign rd_ue    = dec_vld & ((|grp_unc) | (|pad_flag));

  AST_UE_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ue |-> rd_err);                                                       // R6
  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (!rd_err && !rd_ue));                                      // R8

endmodule

// File: tb/burst_ecc_sdp_test.sv
`timescale 1ns/1ps
module ecc_ram_model #(
  parameter int AW = 8,
  parameter int W  = 48
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic [W-1:0]  flip,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [1<<AW];
  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    q = '0;
  end
  always @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr] ^ flip;
  end
endmodule

module burst_ecc_sdp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [47:0] flip = '0;

  logic [31:0] d0, d1;
  logic        v0, v1, e0, e1, u0, u1;
  logic        mwe0, mre0, mwe1, mre1;
  logic [7:0]  mwa0, mra0, mwa1, mra1;
  logic [47:0] mwd0, mrd0, mwd1, mrd1;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burst_ecc_sdp #(.PIPE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(d0), .rd_valid(v0), .rd_err(e0), .rd_ue(u0),
    .mem_we(mwe0), .mem_waddr(mwa0), .mem_wdata(mwd0), .mem_re(mre0), .mem_raddr(mra0),
    .mem_rdata(mrd0));
  burst_ecc_sdp #(.PIPE(1'b1)) uut_p (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(d1), .rd_valid(v1), .rd_err(e1), .rd_ue(u1),
    .mem_we(mwe1), .mem_waddr(mwa1), .mem_wdata(mwd1), .mem_re(mre1), .mem_raddr(mra1),
    .mem_rdata(mrd1));

  ecc_ram_model ram0 (.clk(clk), .we(mwe0), .waddr(mwa0), .wdata(mwd0), .re(mre0),
                      .raddr(mra0), .flip(flip), .q(mrd0));
  ecc_ram_model ram1 (.clk(clk), .we(mwe1), .waddr(mwa1), .wdata(mwd1), .re(mre1),
                      .raddr(mra1), .flip(flip), .q(mrd1));

  typedef struct {
    int          t;
    logic [31:0] d;
    bit          e;
    bit          u;
    string       tag;
  } exp_t;
  exp_t q0[$];
  exp_t q1[$];

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // reference comparison on every clock, away from the active edge
  task automatic cmp_port(input string nm, input bit ev, input exp_t x,
                          input logic v, input logic [31:0] d, input logic e, input logic u);
    string tg;
    tg = ev ? x.tag : "R8";
    chk(ev ? "R7" : "R8", {nm, " rd_valid"}, {31'b0, v}, {31'b0, ev});
    if (ev) begin
      chk(tg, {nm, " rd_data"}, d, x.d);
      chk(tg, {nm, " rd_err"}, {31'b0, e}, {31'b0, x.e});
      chk(tg, {nm, " rd_ue"}, {31'b0, u}, {31'b0, x.u});
    end else begin
      chk("R8", {nm, " idle flags"}, {30'b0, e, u}, 32'b0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      exp_t x0, x1;
      bit   ev0, ev1;
      ev0 = (q0.size() > 0) && (q0[0].t == cyc);
      ev1 = (q1.size() > 0) && (q1[0].t == cyc);
      if (ev0) x0 = q0.pop_front(); else x0 = '{0, '0, 0, 0, ""};
      if (ev1) x1 = q1.pop_front(); else x1 = '{0, '0, 0, 0, ""};
      cmp_port("pipe0", ev0, x0, v0, d0, e0, u0);
      cmp_port("pipe1", ev1, x1, v1, d1, e1, u1);
    end
  end

  task automatic op(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                    input bit re, input logic [7:0] ra, input logic [47:0] fl,
                    input logic [31:0] ed, input bit ee, input bit eu, input string tag);
    @(negedge clk);
    #1;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra; flip = fl;
    if (re) begin
      q0.push_back('{cyc + 1, ed, ee, eu, tag});
      q1.push_back('{cyc + 2, ed, ee, eu, tag});
    end
  endtask

  task automatic wr_rd(input logic [7:0] a, input logic [31:0] d, input logic [47:0] fl,
                       input logic [31:0] ed, input bit ee, input bit eu, input string tag);
    op(1, a, d, 0, '0, '0, '0, 0, 0, tag);
    op(0, '0, '0, 1, a, fl, ed, ee, eu, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state (R8)
    chk("R8", "reset rd_valid", {30'b0, v0, v1}, 32'b0);
    chk("R8", "reset flags", {28'b0, e0, u0, e1, u1}, 32'b0);
    #1 rst_n = 1'b1;

    // R1: clean round trips
    wr_rd(8'd200, 32'hDEADBEEF, '0, 32'hDEADBEEF, 0, 0, "R1");
    wr_rd(8'd201, 32'h00000000, '0, 32'h00000000, 0, 0, "R1");
    wr_rd(8'd202, 32'hFFFFFFFF, '0, 32'hFFFFFFFF, 0, 0, "R1");

    // R2: every single-bit flip
    for (int b = 0; b < 48; b++) begin
      d = $urandom;
      wr_rd(8'(b), d, 48'h1 << b, d, 1, 0, "R2");
    end
    // R3: every adjacent pair
    for (int b = 0; b < 47; b++) begin
      d = $urandom;
      wr_rd(8'(b + 64), d, 48'h3 << b, d, 1, 0, "R3");
    end
    // R4: every adjacent triple
    for (int b = 0; b < 46; b++) begin
      d = $urandom;
      wr_rd(8'(b + 128), d, 48'h7 << b, d, 1, 0, "R4");
    end

    // R5: double errors inside group 0
    d = $urandom;
    wr_rd(8'd210, d, (48'h1 << 3) | (48'h1 << 6), d, 1, 1, "R5");
    d = $urandom;
    wr_rd(8'd211, d, (48'h1 << 9) | (48'h1 << 12), d ^ 32'h1, 1, 1, "R5");

    // R7: back-to-back reads, R1: write and read in the same cycle
    op(1, 8'd220, 32'h11112222, 0, '0, '0, '0, 0, 0, "R7");
    op(1, 8'd221, 32'h33334444, 0, '0, '0, '0, 0, 0, "R7");
    op(1, 8'd222, 32'h55556666, 1, 8'd220, '0, 32'h11112222, 0, 0, "R1");
    op(0, '0, '0, 1, 8'd221, 48'h1 << 20, 32'h33334444, 1, 0, "R7");
    op(0, '0, '0, 1, 8'd222, '0, 32'h55556666, 0, 0, "R7");
    op(0, '0, '0, 0, '0, '0, '0, 0, 0, "R7");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule